// File: doc/BRIEF.md
# Multichannel PCM Bit-Plane Packer

The block takes one stereo frame (a left and a right 32-bit slot for each of several stereo lanes) and turns it into 64 bytes. Each byte is one serial bit period for every lane at once. Bit 0 of the byte carries the word-select level. Bit p+1 carries serial data lane p. A downstream FIFO can therefore be read out byte by byte at the serial bit clock and drive the serial audio pins directly, with no serialiser at the far end.

Frames arrive as a parallel bundle under a valid/ready handshake. Bytes leave under a second valid/ready handshake. Each lane can be switched off, in which case it sends zeros. Each lane can also be set to carry a 1-bit stream: its left and right slots then hold 64 consecutive stream bits, sent unmasked. PCM lanes hold samples of `PCM_BITS` valid bits, left-aligned, and the bits below them are sent as zero.

Control is a two-state machine. In `ST_IDLE` the block offers `in_ready`. Transition `ACCEPT` (`in_valid` while idle) captures the frame and moves to `ST_SEND`. `ST_SEND` presents bytes and loops on itself while bytes remain or the sink stalls. Transition `DRAIN_DONE` (the sink takes byte 63) returns to `ST_IDLE`.

Top module: `bitplane_packer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: A frame is captured on a cycle with `in_valid` and `in_ready` both high. From the next cycle `out_valid` is 1 and `in_ready` is 0 until the last byte of that frame has been taken.
- R3: Bit 0 of byte k (k = 0..63, in output order) is 1 for k = 31..62 and 0 for k = 0..30 and k = 63.
- R4: For an enabled PCM lane p, bit p+1 of byte k is left-slot bit 31-k for k = 0..31, and right-slot bit 63-k for k = 32..63. The left slot is `in_left[p*32 +: 32]` and the right slot is `in_right[p*32 +: 32]`.
- R5: On an enabled PCM lane, slot bits below bit 32-`PCM_BITS` are sent as 0 whatever their input value (default `PCM_BITS` = 24, so slot bits 7..0 are sent as 0).
- R6: A lane with `lane_dsd[p]` = 1 sends all 32 bits of both slots unmasked, in the R4 order.
- R7: A lane with `lane_en[p]` = 0 sends 0 in all 64 bytes.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_byte` and the byte position hold, so no byte is skipped.
- R9: Changes to `in_left`, `in_right`, `lane_en` and `lane_dsd` after capture have no effect on the bytes of the frame being sent.
- R10: Exactly 64 bytes are sent per frame. The cycle after byte 63 is taken, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame bundle valid |
| in_ready | output | 1 | Block can capture a frame |
| in_left | input | NUM_PAIRS*32 | Left slots, lane p at bits p*32+31..p*32 |
| in_right | input | NUM_PAIRS*32 | Right slots, same packing |
| lane_en | input | NUM_PAIRS | Per-lane enable |
| lane_dsd | input | NUM_PAIRS | Per-lane 1-bit stream mode |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the byte |
| out_byte | output | NUM_PAIRS+1 | Word select in bit 0, lane p in bit p+1 |

## Verification
The first byte of a frame is due one cycle after the capture edge, and each later byte one cycle after the edge where the previous byte was taken. The bench drives inputs on the falling edge and checks at the next falling edge, so it compares each byte against its own byte counter, which advances only on a cycle where it raised `out_ready`. A stalled byte is compared against the copy taken one cycle earlier. `in_ready` is checked as due in the cycle after byte 63 is taken. The captured inputs are scrambled in the cycle right after capture to show that R9 holds.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } bp_state_e;

    // Mask that keeps the top `used` bits of a `width`-bit slot
    function automatic logic [63:0] top_bits_mask(input int width, input int used);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < width && b >= width - used) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/bp_lane_store.sv
module bp_lane_store #(
    parameter int NUM_PAIRS = 7,
    parameter int SLOT_W    = 32,
    parameter int PCM_BITS  = 24,
    localparam int WORD_W   = 2 * SLOT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [NUM_PAIRS*SLOT_W-1:0]   left_in,
    input  logic [NUM_PAIRS*SLOT_W-1:0]   right_in,
    input  logic [NUM_PAIRS-1:0]          en_in,
    input  logic [NUM_PAIRS-1:0]          dsd_in,
    output logic [NUM_PAIRS*WORD_W-1:0]   words
);
    import bp_pkg::*;

    localparam logic [63:0] MASK_FULL = top_bits_mask(SLOT_W, PCM_BITS);
    localparam logic [SLOT_W-1:0] PCM_MASK = MASK_FULL[SLOT_W-1:0];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_lane
        logic [SLOT_W-1:0] keep;
        assign keep = dsd_in[p] ? '1 : PCM_MASK;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[p*WORD_W +: WORD_W] <= '0;
            end else if (load) begin
                if (en_in[p]) begin
                    words[p*WORD_W +: WORD_W] <= {left_in[p*SLOT_W +: SLOT_W] & keep,
                                                  right_in[p*SLOT_W +: SLOT_W] & keep};
                end else begin
                    words[p*WORD_W +: WORD_W] <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bp_byte_counter.sv
module bp_byte_counter #(
    parameter int FRAME_BYTES = 64,
    localparam int IDX_W      = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    assign last = (idx == IDX_W'(FRAME_BYTES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    // R10
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !clear) |=> idx == IDX_W'($past(idx) + 1'b1));

    // R8
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(idx));
endmodule

// File: rtl/bp_plane_mux.sv
module bp_plane_mux #(
    parameter int NUM_PAIRS = 7,
    parameter int SLOT_W    = 32,
    localparam int WORD_W   = 2 * SLOT_W,
    localparam int IDX_W    = $clog2(WORD_W)
) (
    input  logic [IDX_W-1:0]              idx,
    input  logic [NUM_PAIRS*WORD_W-1:0]   words,
    output logic [NUM_PAIRS:0]            plane
);
    logic [IDX_W-1:0] sel;
    assign sel = IDX_W'(WORD_W - 1) - idx;

    // Word select leads the data by one bit period
    assign plane[0] = (idx >= IDX_W'(SLOT_W - 1)) && (idx != IDX_W'(WORD_W - 1));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_bit
        logic [WORD_W-1:0] w;
        assign w          = words[p*WORD_W +: WORD_W];
        assign plane[p+1] = w[sel];
    end
endmodule

// File: rtl/bitplane_packer.sv
module bitplane_packer #(
    parameter int NUM_PAIRS = 7,
    parameter int SLOT_W    = 32,
    parameter int PCM_BITS  = 24,
    localparam int WORD_W   = 2 * SLOT_W,
    localparam int IDX_W    = $clog2(WORD_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [NUM_PAIRS*SLOT_W-1:0]   in_left,
    input  logic [NUM_PAIRS*SLOT_W-1:0]   in_right,
    input  logic [NUM_PAIRS-1:0]          lane_en,
    input  logic [NUM_PAIRS-1:0]          lane_dsd,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [NUM_PAIRS:0]            out_byte
);
    import bp_pkg::*;

    bp_state_e state, state_nx;
    logic load, step, last;
    logic [IDX_W-1:0] idx;
    logic [NUM_PAIRS*WORD_W-1:0] words;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)           state_nx = ST_SEND;  // ACCEPT
            ST_SEND: if (out_ready && last)  state_nx = ST_IDLE;  // DRAIN_DONE
            default:                         state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_SEND);
        load      = in_ready && in_valid;
        step      = out_valid && out_ready;
    end

    bp_lane_store #(.NUM_PAIRS(NUM_PAIRS), .SLOT_W(SLOT_W), .PCM_BITS(PCM_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .load(load),
        .left_in(in_left), .right_in(in_right),
        .en_in(lane_en), .dsd_in(lane_dsd), .words(words)
    );

    bp_byte_counter #(.FRAME_BYTES(WORD_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
        .idx(idx), .last(last)
    );

    bp_plane_mux #(.NUM_PAIRS(NUM_PAIRS), .SLOT_W(SLOT_W)) u_mux (
        .idx(idx), .words(words), .plane(out_byte)
    );

    // R2
    accept_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R10
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && last) |=> (in_ready && !out_valid));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R3
    ws_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !out_byte[0]);
endmodule

// File: tb/tb_bitplane_packer.sv
module tb_bitplane_packer;
    localparam int NP = 7;
    localparam int SW = 32;
    localparam int PB = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [NP*SW-1:0] in_left = '0;
    logic [NP*SW-1:0] in_right = '0;
    logic [NP-1:0] lane_en = '0;
    logic [NP-1:0] lane_dsd = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [NP:0] out_byte;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] fl [NP];
    logic [31:0] fr [NP];
    logic [NP-1:0] fen, fdsd;

    bitplane_packer #(.NUM_PAIRS(NP), .SLOT_W(SW), .PCM_BITS(PB)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .lane_en(lane_en), .lane_dsd(lane_dsd),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic bit exp_bit(input int p, input int k);
        logic [31:0] m;
        logic [63:0] w;
        m = 32'hFFFF_FFFF << (32 - PB);
        if (!fen[p]) return 1'b0;
        if (fdsd[p]) w = {fl[p], fr[p]};
        else         w = {fl[p] & m, fr[p] & m};
        return w[63 - k];
    endfunction

    function automatic string lane_tag(input int p, input int k);
        int sb;
        sb = 31 - (k % 32);
        if (!fen[p])               return "R7 disabled lane";
        if (fdsd[p])               return "R6 stream lane";
        if (sb < 32 - PB)          return "R5 masked bit";
        return "R4 lane data";
    endfunction

    task automatic run_frame(input int stall_pct);
        int k;
        bit pend;
        logic [NP:0] held;
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready before capture", 32'(in_ready), 1);
        for (int p = 0; p < NP; p++) begin
            in_left[p*SW +: SW]  = fl[p];
            in_right[p*SW +: SW] = fr[p];
        end
        lane_en  = fen;
        lane_dsd = fdsd;
        in_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        // R9: scramble the inputs after capture
        for (int p = 0; p < NP; p++) begin
            in_left[p*SW +: SW]  = $urandom;
            in_right[p*SW +: SW] = $urandom;
        end
        lane_en  = NP'($urandom);
        lane_dsd = NP'($urandom);
        k = 0;
        pend = 0;
        held = '0;
        while (k < 64) begin
            chk(out_valid == 1'b1, "R2 valid while sending", 32'(out_valid), 1);
            chk(in_ready == 1'b0, "R2 ready low while sending", 32'(in_ready), 0);
            if (pend) chk(out_byte == held, "R8 stalled byte held", 32'(out_byte), 32'(held));
            chk(out_byte[0] == ((k >= 31) && (k <= 62)), "R3 word select", 32'(out_byte[0]),
                32'((k >= 31) && (k <= 62)));
            for (int p = 0; p < NP; p++) begin
                chk(out_byte[p+1] == exp_bit(p, k), $sformatf("%s R9 lane %0d byte %0d", lane_tag(p, k), p, k),
                    32'(out_byte[p+1]), 32'(exp_bit(p, k)));
            end
            out_ready = (($urandom % 100) >= stall_pct);
            pend = !out_ready;
            held = out_byte;
            if (out_ready) k++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(in_ready == 1'b1, "R10 ready after last byte", 32'(in_ready), 1);
        chk(out_valid == 1'b0, "R10 valid low after last byte", 32'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle without input", 32'(out_valid), 0);

        // Directed: all ones, all PCM, all enabled (R5 masking)
        for (int p = 0; p < NP; p++) begin fl[p] = '1; fr[p] = '1; end
        fen = '1; fdsd = '0;
        run_frame(0);

        // Directed: all ones, all stream lanes (R6 unmasked)
        fdsd = '1;
        run_frame(0);

        // Directed: lanes disabled with live data (R7), distinct patterns
        for (int p = 0; p < NP; p++) begin
            fl[p] = 32'h8000_0001 ^ (32'h0101_0101 << p);
            fr[p] = 32'h7FFF_FF00 ^ (32'h1000_0000 >> p);
        end
        fen = 7'b1010101; fdsd = 7'b0000110;
        run_frame(0);

        // Random frames with back-pressure (R8)
        for (int f = 0; f < 24; f++) begin
            for (int p = 0; p < NP; p++) begin fl[p] = $urandom; fr[p] = $urandom; end
            fen  = NP'($urandom);
            fdsd = NP'($urandom);
            run_frame((f % 3 == 0) ? 0 : 40);
        end

        finish_run();
    end
endmodule